// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives one pulse-width-modulated output from an 8-bit timer whose count is extended by two fine bits. The fine bits come from the prescaler, which gives a 10-bit time base. A period register sets when the timer wraps. A 10-bit duty value sets when the output drops within each period. The timer advances once every four input clocks times a selectable prescale factor of 1, 4 or 16.

Software writes the duty value in two fields: an upper byte and a lower 2-bit part. Both go to a buffer. The buffer is copied into the active compare register only at the instant the timer wraps, so a new duty value never cuts a period short or stretches it. A mode enable, when low, holds the timer at zero and forces the output low.

Top module: `pwm_timer_gen`

## Requirements
- R1: After reset the output is 0, the period register holds 0xFF, and the duty buffer and active duty are 0. With an untouched period register, the period is 1024 input clocks at prescale 1.
- R2: The prescale select encoding is 00 = 1, 01 = 4, 10 or 11 = 16. One period lasts (period + 1) × 4 × prescale input clocks.
- R3: The output rises only at the wrap from the period value to zero, and it rises there whenever the newly latched duty is nonzero.
- R4: A latched duty of 0 keeps the output low for the whole period.
- R5: The duty value is {upper byte, lower 2 bits}. For a duty D below (period + 1) × 4, the output is high for exactly D × prescale input clocks at the start of each period. It drops when {timer, fine bits} reaches D.
- R6: A duty write made during a period has no effect on that period. The buffered value takes effect at the next wrap.
- R7: A duty of (period + 1) × 4 or more keeps the output high for the entire period. It stays high across consecutive periods.
- R8: While the enable is low, the timer stays at 0 and the output is 0 one clock after the enable falls. After the enable rises, the output stays low for one full period length before the first wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Mode enable; low holds the timer and clears the output |
| presc_sel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | TW | Period register write data |
| duty_hi_we | input | 1 | Write strobe for the upper duty byte (buffer) |
| duty_hi_wdata | input | TW | Upper duty byte data |
| duty_lo_we | input | 1 | Write strobe for the lower duty bits (buffer) |
| duty_lo_wdata | input | 2 | Lower duty bits data |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running period. The test must show that the write changes nothing until the following wrap. The stimulus enables the block and counts input clocks past the first wrap, which it computes from the period and prescale. It then writes a new duty in both fields at once. The expected waveform keeps the old high time for the current period and switches to the new one only afterwards. Separate runs cover each prescale code, a zero duty, and duties on both sides of the full-period boundary.

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen #(
  parameter int TW = 8,
  parameter logic [TW-1:0] PERIOD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    presc_sel,
  input  logic          period_we,
  input  logic [TW-1:0] period_wdata,
  input  logic          duty_hi_we,
  input  logic [TW-1:0] duty_hi_wdata,
  input  logic          duty_lo_we,
  input  logic [1:0]    duty_lo_wdata,
  output logic          pwm_out
);
  localparam int PW = 6;
  localparam int DW = TW + 2;

  logic [PW-1:0] pcnt, pcnt_nxt, plast;
  logic [TW-1:0] tmr, tmr_nxt, period_q, duty_hi_q;
  logic [1:0]    duty_lo_q, fine_nxt;
  logic [DW-1:0] duty_buf, duty_act, base_nxt;
  logic          tick, rollover, pwm_q;

  always_comb begin
    case (presc_sel)
      2'b00:   plast = PW'(3);
      2'b01:   plast = PW'(15);
      default: plast = PW'(63);
    endcase
  end

  assign tick     = pcnt >= plast;
  assign rollover = tick && (tmr == period_q);
  assign pcnt_nxt = tick ? '0 : pcnt + 1'b1;
  assign tmr_nxt  = rollover ? '0 : (tick ? tmr + 1'b1 : tmr);

  always_comb begin
    case (presc_sel)
      2'b00:   fine_nxt = pcnt_nxt[1:0];
      2'b01:   fine_nxt = pcnt_nxt[3:2];
      default: fine_nxt = pcnt_nxt[5:4];
    endcase
  end

  assign base_nxt = {tmr_nxt, fine_nxt};
  assign duty_buf = {duty_hi_q, duty_lo_q};
  assign pwm_out  = pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= PERIOD_RST;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
    end else begin
      if (period_we)  period_q  <= period_wdata;
      if (duty_hi_we) duty_hi_q <= duty_hi_wdata;
      if (duty_lo_we) duty_lo_q <= duty_lo_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      tmr      <= '0;
      duty_act <= '0;
      pwm_q    <= 1'b0;
    end else if (!en) begin
      pcnt  <= '0;
      tmr   <= '0;
      pwm_q <= 1'b0;
    end else begin
      pcnt <= pcnt_nxt;
      tmr  <= tmr_nxt;
      if (rollover) begin
        duty_act <= duty_buf;
        pwm_q    <= (duty_buf != '0);
      end else if (base_nxt == duty_act) begin
        pwm_q <= 1'b0;
      end
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out); // R8
  AST_OFF_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr == '0)); // R8
  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(rollover && en)); // R3
  AST_ZERO_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && duty_buf == '0) |=> !pwm_out); // R4
  AST_DUTY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rollover) |=> (duty_act == $past(duty_buf))); // R6
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && rollover) |=> $stable(duty_act)); // R6
endmodule

// File: tb/pwm_timer_gen_tb_top.sv
module pwm_timer_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] presc_sel = 2'b00;
  logic period_we = 1'b0, duty_hi_we = 1'b0, duty_lo_we = 1'b0;
  logic [7:0] period_wdata = '0, duty_hi_wdata = '0;
  logic [1:0] duty_lo_wdata = '0;
  logic pwm_out;

  always #4 clk = ~clk;

  pwm_timer_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .presc_sel(presc_sel),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
    .duty_lo_we(duty_lo_we), .duty_lo_wdata(duty_lo_wdata),
    .pwm_out(pwm_out)
  );

  typedef struct { logic lvl; int n; string tag; } seg_t;
  seg_t q[$];
  int n_cmp = 0, n_err = 0;
  int rem = 0, off = 0;
  logic bad = 1'b0, got = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic add_seg(input logic lvl, input int n, input string tag);
    seg_t s;
    if (n > 0) begin
      s.lvl = lvl; s.n = n; s.tag = tag;
      q.push_back(s);
    end
  endtask

  function automatic int presc(input logic [1:0] ps);
    return (ps == 2'b00) ? 1 : (ps == 2'b01) ? 4 : 16;
  endfunction

  task automatic push_periods(input int pr, input int d, input logic [1:0] ps,
                              input int nper, input string tag);
    int p, len, h;
    p = presc(ps);
    len = (pr + 1) * 4 * p;
    h = (d >= (pr + 1) * 4) ? len : d * p;
    for (int i = 0; i < nper; i++) begin
      add_seg(1'b1, h, tag);
      add_seg(1'b0, len - h, tag);
    end
  endtask

  task automatic start_run(input bit do_pr, input int pr, input logic [7:0] hi,
                           input logic [1:0] lo, input logic [1:0] ps,
                           input int nper, input string tag);
    @(posedge clk); #2;
    period_we = do_pr; period_wdata = 8'(pr);
    duty_hi_we = 1'b1; duty_hi_wdata = hi;
    duty_lo_we = 1'b1; duty_lo_wdata = lo;
    presc_sel = ps;
    @(posedge clk); #2;
    period_we = 1'b0; duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    en = 1'b1;
    add_seg(1'b0, (pr + 1) * 4 * presc(ps), "R8");
    push_periods(pr, {hi, lo}, ps, nper, tag);
  endtask

  task automatic end_run();
    wait (q.size() == 0);
    @(posedge clk); #2;
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8 output low after disable", int'(pwm_out), 0);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      if (rem == 0) begin rem = q[0].n; bad = 1'b0; end
      if (pwm_out !== q[0].lvl && !bad) begin
        bad = 1'b1; got = pwm_out; off = q[0].n - rem;
      end
      rem--;
      if (rem == 0) begin
        n_cmp++;
        if (bad) begin
          n_err++;
          $display("FAIL %s: level segment sample %0d actual %0b expected %0b",
                   q[0].tag, off, got, q[0].lvl);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 output low after reset", int'(pwm_out), 0);

    // R1: default period 0xFF, duty 1, prescale 1
    start_run(1'b0, 255, 8'd0, 2'd1, 2'b00, 2, "R1");
    end_run();
    // R2 / R5: prescale codes
    start_run(1'b1, 5, 8'd3, 2'd2, 2'b00, 3, "R2 R5 ps00");
    end_run();
    start_run(1'b1, 3, 8'd1, 2'd1, 2'b01, 2, "R2 R5 ps01");
    end_run();
    start_run(1'b1, 2, 8'd1, 2'd3, 2'b10, 2, "R2 R5 ps10");
    end_run();
    start_run(1'b1, 1, 8'd0, 2'd3, 2'b11, 2, "R2 R5 ps11");
    end_run();
    // R4: zero duty
    start_run(1'b1, 4, 8'd0, 2'd0, 2'b00, 3, "R4");
    end_run();
    // R7: duty equal to full period count, then above it
    start_run(1'b1, 4, 8'd5, 2'd0, 2'b00, 3, "R7");
    end_run();
    start_run(1'b1, 4, 8'd40, 2'd3, 2'b00, 2, "R7 large");
    end_run();
    // R5 boundary: one below full
    start_run(1'b1, 4, 8'd4, 2'd3, 2'b00, 2, "R5 boundary");
    end_run();
    // R5/R3: minimum nonzero duty
    start_run(1'b1, 2, 8'd0, 2'd1, 2'b00, 3, "R3 R5 min");
    end_run();
    // R6: duty 10 then mid-period write of 25, period 8 ticks
    start_run(1'b1, 7, 8'd2, 2'd2, 2'b00, 1, "R6 old duty");
    repeat (36) @(posedge clk);
    #2;
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd6;
    duty_lo_we = 1'b1; duty_lo_wdata = 2'd1;
    @(posedge clk); #2;
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    push_periods(7, 25, 2'b00, 2, "R6 new duty");
    end_run();
    // R3 R6: zero duty then nonzero written mid-run
    start_run(1'b1, 3, 8'd0, 2'd0, 2'b00, 1, "R3 zero first");
    repeat (20) @(posedge clk);
    #2;
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd2;
    @(posedge clk); #2;
    duty_hi_we = 1'b0;
    push_periods(3, 8, 2'b00, 2, "R3 R6 set after zero");
    end_run();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule